// File: doc/BRIEF.md
# Per-Core Banked Timer Access Router

This block decodes one shared 32-bit register bus into a bank of per-core private timers. It sits between the bus and 1 to 4 timer instances. The timers, the bus fabric and the interrupt controllers are outside this block. The address space is split into windows of 32 bytes each.

- Window 0 is a "current core" alias. The core ID that comes with the access steers it to that core's own timer, so the same address reaches a different timer for each requester.
- Window k+1 reaches core k's timer directly, so any core can inspect or program any other core's timer.

The offset within a window goes to the selected timer unchanged. Read data is multiplexed back from that timer and registered, so it appears one cycle after the request. Each timer's interrupt line goes out on the matching per-core output.

Accesses that cannot be served are rejected. A transfer that is not a full aligned word is a fault. An alias access from a core ID with no timer is also a fault. For both, the block selects no timer, the read returns zero and an error flag pulses for one cycle. Windows above the last timer read zero and drop writes quietly. A core count outside 1..4 is rejected when the design is elaborated.

Top module: `tmr_bank_router`

## Requirements
- R1: An accepted access to window 0 (address bits [7:5] = 0) strobes only the timer whose index equals `bus_core_id`. A read returns that timer's data.
- R2: An accepted access to window w, for 1 <= w <= NUM_CORES, strobes only timer w-1, whatever the value of `bus_core_id`.
- R3: The window offset (address bits [4:0]), the write data and the write flag reach the timer side unchanged in the request cycle.
- R4: An access is accepted only if `bus_be` is 4'hF and address bits [1:0] are 0. Any other access strobes no timer, its write changes no timer, it reads zero, and `bus_err` is 1 in the following cycle.
- R5: A window-0 access with `bus_core_id` >= NUM_CORES strobes no timer, drops its write and reads zero. `bus_err` is 1 in the following cycle only, for one cycle.
- R6: An access to a window above NUM_CORES strobes no timer, drops its write, reads zero and raises no error.
- R7: Read data from an accepted read appears on `bus_rdata` exactly one cycle after the request. In any cycle that does not follow an accepted read (a write or an idle cycle), `bus_rdata` is zero.
- R8: `irq_out[k]` follows `tmr_irq[k]` for every core k, in the same cycle.
- R9: At most one bit of `tmr_sel` is set, and none is set without `bus_req`.
- R10: During and right after reset, `bus_rdata` is zero, `bus_err` is 0 and no timer is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bits [7:5] window number, bits [4:0] offset |
| bus_be | input | DATA_W/8 | Byte enables; all set for an accepted access |
| bus_core_id | input | CID_W | Index of the core issuing the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, one cycle after the request |
| bus_err | output | 1 | One-cycle fault pulse, one cycle after the request |
| tmr_sel | output | NUM_CORES | One-hot strobe to the selected timer |
| tmr_we | output | 1 | Write flag to the timers |
| tmr_off | output | 5 | Offset within the window |
| tmr_wdata | output | DATA_W | Write data to the timers |
| tmr_rdata | input | NUM_CORES*DATA_W | Read data of each timer, core k in slice k |
| tmr_irq | input | NUM_CORES | Interrupt request of each timer |
| irq_out | output | NUM_CORES | Per-core interrupt outputs |

## Verification
The assertions check the routing on every cycle:
- the strobe is one-hot or zero, and never present without a request;
- each accepted alias or fixed-window access strobes the expected timer;
- faults and out-of-range windows strobe nothing;
- every fault is followed by an error pulse and zero read data;
- `bus_rdata` stays zero after any cycle that was not a read.

Whether a dropped write really left every timer untouched, and whether a write through the alias is visible through the fixed window of the same core, can only be shown by the bench scenarios. They do this by reading the timers back through the normal windows.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;
  localparam int unsigned OFF_W     = 5;
  localparam int unsigned MAX_CORES = 4;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_HIT   = 2'd1,
    ACC_MISS  = 2'd2,
    ACC_FAULT = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/tmr_route_decode.sv
module tmr_route_decode
  import tmr_route_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CID_W     = 2,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned BE_W      = 4
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [CID_W-1:0]  core_id,
  output acc_kind_e         kind,
  output logic [CID_W-1:0]  tgt
);
  localparam int unsigned WIN_W   = ADDR_W - OFF_W;
  localparam int unsigned ALIGN_W = (BE_W > 1) ? $clog2(BE_W) : 1;

  logic [WIN_W-1:0] win;
  logic             whole_word;

  assign win        = addr[ADDR_W-1:OFF_W];
  assign whole_word = (be == {BE_W{1'b1}}) && (addr[ALIGN_W-1:0] == '0);

  always_comb begin
    kind = ACC_NONE;
    tgt  = '0;
    if (req) begin
      if (!whole_word) begin
        kind = ACC_FAULT;
      end else if (win == '0) begin
        if (32'(core_id) < NUM_CORES) begin
          kind = ACC_HIT;
          tgt  = core_id;
        end else begin
          kind = ACC_FAULT;
        end
      end else if (32'(win) <= NUM_CORES) begin
        kind = ACC_HIT;
        tgt  = CID_W'(win - WIN_W'(1));
      end else begin
        kind = ACC_MISS;
      end
    end
  end
endmodule

// File: rtl/tmr_route_strobe.sv
module tmr_route_strobe
  import tmr_route_pkg::*;
#(
  parameter int unsigned CID_W     = 2,
  parameter int unsigned NUM_CORES = 4
) (
  input  acc_kind_e              kind,
  input  logic [CID_W-1:0]       tgt,
  output logic [NUM_CORES-1:0]   sel
);
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_sel
    assign sel[k] = (kind == ACC_HIT) && (tgt == CID_W'(k));
  end
endmodule

// File: rtl/tmr_route_resp.sv
module tmr_route_resp
  import tmr_route_pkg::*;
#(
  parameter int unsigned CID_W     = 2,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  acc_kind_e                   kind,
  input  logic                        we,
  input  logic [CID_W-1:0]            tgt,
  input  logic [NUM_CORES*DATA_W-1:0] tmr_rdata,
  output logic [DATA_W-1:0]           rdata,
  output logic                        err
);
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              err_d, err_q;
  logic              live_d, live_q;
  logic              rsp_en;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (tgt == CID_W'(k)) picked = tmr_rdata[k*DATA_W +: DATA_W];
    end
  end

  // Registers load while a request is present or one was present last cycle.
  assign live_d  = (kind != ACC_NONE);
  assign rsp_en  = live_d || live_q;
  assign rdata_d = ((kind == ACC_HIT) && !we) ? picked : '0;
  assign err_d   = (kind == ACC_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      live_q <= live_d;
      if (rsp_en) begin
        rdata_q <= rdata_d;
        err_q   <= err_d;
      end
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/tmr_bank_router.sv
module tmr_bank_router
  import tmr_route_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CID_W     = 2,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W/8-1:0]         bus_be,
  input  logic [CID_W-1:0]            bus_core_id,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_err,
  output logic [NUM_CORES-1:0]        tmr_sel,
  output logic                        tmr_we,
  output logic [OFF_W-1:0]            tmr_off,
  output logic [DATA_W-1:0]           tmr_wdata,
  input  logic [NUM_CORES*DATA_W-1:0] tmr_rdata,
  input  logic [NUM_CORES-1:0]        tmr_irq,
  output logic [NUM_CORES-1:0]        irq_out
);
  localparam int unsigned BE_W = DATA_W / 8;

  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES || NUM_CORES > (1 << CID_W)) begin : g_bad_cores
    $error("tmr_bank_router: NUM_CORES must lie in 1..4 and fit the core ID");
  end

  acc_kind_e        kind;
  logic [CID_W-1:0] tgt;

  tmr_route_decode #(
    .ADDR_W(ADDR_W), .CID_W(CID_W), .NUM_CORES(NUM_CORES), .BE_W(BE_W)
  ) u_decode (
    .req(bus_req), .addr(bus_addr), .be(bus_be), .core_id(bus_core_id),
    .kind(kind), .tgt(tgt)
  );

  tmr_route_strobe #(
    .CID_W(CID_W), .NUM_CORES(NUM_CORES)
  ) u_strobe (
    .kind(kind), .tgt(tgt), .sel(tmr_sel)
  );

  tmr_route_resp #(
    .CID_W(CID_W), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .kind(kind), .we(bus_we), .tgt(tgt),
    .tmr_rdata(tmr_rdata), .rdata(bus_rdata), .err(bus_err)
  );

  assign tmr_we    = bus_we;
  assign tmr_off   = bus_addr[OFF_W-1:0];
  assign tmr_wdata = bus_wdata;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_irq
    assign irq_out[k] = tmr_irq[k];
  end
endmodule

// File: rtl/tmr_bank_router_chk.sv
module tmr_bank_router_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CID_W     = 2,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W/8-1:0]  bus_be,
  input logic [CID_W-1:0]     bus_core_id,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 bus_err,
  input logic [NUM_CORES-1:0] tmr_sel,
  input logic [NUM_CORES-1:0] tmr_irq,
  input logic [NUM_CORES-1:0] irq_out
);
  localparam int unsigned WIN_W = ADDR_W - 5;
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned AL_W  = (BE_W > 1) ? $clog2(BE_W) : 1;

  logic [WIN_W-1:0]     win;
  logic                 whole;
  logic [NUM_CORES-1:0] own_bit;

  assign win     = bus_addr[ADDR_W-1:5];
  assign whole   = (bus_be == {BE_W{1'b1}}) && (bus_addr[AL_W-1:0] == '0);
  assign own_bit = NUM_CORES'(1) << bus_core_id;

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel));
  // R9
  sel_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> tmr_sel == '0);
  // R1
  alias_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && whole && win == '0 && 32'(bus_core_id) < NUM_CORES |-> tmr_sel == own_bit);
  // R2
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_fixed
    fixed_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && whole && 32'(win) == k + 1 |-> tmr_sel == NUM_CORES'(1) << k);
  end
  // R4
  partial_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !whole |-> tmr_sel == '0);
  // R4
  partial_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !whole |=> bus_err && bus_rdata == '0);
  // R5
  bad_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && whole && win == '0 && 32'(bus_core_id) >= NUM_CORES |=> bus_err && bus_rdata == '0);
  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_req));
  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && whole && 32'(win) > NUM_CORES |=> !bus_err && bus_rdata == '0);
  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req || bus_we |=> bus_rdata == '0);
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == tmr_irq);
  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (bus_rdata == '0 && !bus_err);
    end
  end
endmodule

bind tmr_bank_router tmr_bank_router_chk #(
  .ADDR_W(ADDR_W), .CID_W(CID_W), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_core_id(bus_core_id),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .tmr_sel(tmr_sel),
  .tmr_irq(tmr_irq), .irq_out(irq_out)
);

// File: tb/tb_tmr_bank_router.sv
module tb_tmr_bank_router;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [3:0]    bus_be = 4'hF;
  logic [1:0]    bus_core_id = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [NC-1:0] tmr_sel;
  logic          tmr_we;
  logic [4:0]    tmr_off;
  logic [31:0]   tmr_wdata;
  logic [NC*32-1:0] tmr_rdata;
  logic [NC-1:0] tmr_irq = '0;
  logic [NC-1:0] irq_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_bank_router #(.NUM_CORES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_core_id(bus_core_id),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .tmr_sel(tmr_sel), .tmr_we(tmr_we), .tmr_off(tmr_off),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata), .tmr_irq(tmr_irq),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] seed(int k, int w);
    return 32'hA500_0000 | (k << 8) | w;
  endfunction

  // Simple timer register models, eight words each.
  logic [31:0] tmem [NC][8];
  logic [31:0] expm [NC][8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++)
        for (int w = 0; w < 8; w++) tmem[k][w] <= seed(k, w);
    end else begin
      for (int k = 0; k < NC; k++)
        if (tmr_sel[k] && tmr_we) tmem[k][tmr_off[4:2]] <= tmr_wdata;
    end
  end

  always_comb
    for (int k = 0; k < NC; k++) tmr_rdata[k*32 +: 32] = tmem[k][tmr_off[4:2]];

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  logic [31:0] r_data;
  logic        r_err;
  logic [NC-1:0] r_sel;
  logic [4:0]  r_off;
  logic        r_we;
  logic [31:0] r_wd;

  task automatic acc(int win, int off, int cid, bit we, logic [31:0] wd, logic [3:0] be);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = {3'(win), 5'(off)};
    bus_core_id = 2'(cid); bus_wdata = wd; bus_be = be;
    #1;
    r_sel = tmr_sel; r_off = tmr_off; r_we = tmr_we; r_wd = tmr_wdata;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_be = 4'hF;
    r_data = bus_rdata; r_err = bus_err;
  endtask

  task automatic t_reset;
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 err", 32'(bus_err), 0);
    chk("R10 sel", 32'(tmr_sel), 0);
  endtask

  task automatic t_alias;
    for (int c = 0; c < NC; c++) begin
      acc(0, 4 * (c + 1), c, 0, 0, 4'hF);
      chk("R1 alias sel", 32'(r_sel), 32'(1 << c));
      chk("R1 alias data", r_data, expm[c][c + 1]);
    end
    acc(0, 8, 1, 1, 32'h1234_5678, 4'hF);
    chk("R1 alias write sel", 32'(r_sel), 32'b010);
    expm[1][2] = 32'h1234_5678;
    acc(2, 8, 0, 0, 0, 4'hF);
    chk("R1 alias write seen via fixed", r_data, 32'h1234_5678);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < NC; k++) begin
      acc(k + 1, 5'h1C, (k + 1) % NC, 0, 0, 4'hF);
      chk("R2 fixed sel", 32'(r_sel), 32'(1 << k));
      chk("R2 fixed data", r_data, expm[k][7]);
      chk("R9 single strobe", $countones(r_sel), 1);
    end
    acc(3, 5'h14, 0, 1, 32'hCAFE_0003, 4'hF);
    expm[2][5] = 32'hCAFE_0003;
    chk("R3 offset", 32'(r_off), 32'h14);
    chk("R3 wdata", r_wd, 32'hCAFE_0003);
    chk("R3 we", 32'(r_we), 1);
    acc(3, 5'h14, 1, 0, 0, 4'hF);
    chk("R2 fixed write readback", r_data, 32'hCAFE_0003);
  endtask

  task automatic t_latency;
    acc(1, 0, 2, 0, 0, 4'hF);
    chk("R7 read next cycle", r_data, expm[0][0]);
    @(negedge clk);
    chk("R7 idle after read", bus_rdata, 0);
    acc(1, 4, 0, 1, 32'h0BAD_F00D, 4'hF);
    expm[0][1] = 32'h0BAD_F00D;
    chk("R7 write reads zero", r_data, 0);
  endtask

  task automatic t_partial;
    acc(1, 12, 0, 1, 32'hDEAD_0001, 4'h3);
    chk("R4 byte-lane fault err", 32'(r_err), 1);
    chk("R4 byte-lane no sel", 32'(r_sel), 0);
    acc(1, 12, 0, 0, 0, 4'hF);
    chk("R4 write dropped", r_data, expm[0][3]);
    acc(2, 6, 0, 0, 0, 4'hF);
    chk("R4 misaligned err", 32'(r_err), 1);
    chk("R4 misaligned reads zero", r_data, 0);
  endtask

  task automatic t_badcore;
    acc(0, 0, 3, 1, 32'hFFFF_FFFF, 4'hF);
    chk("R5 bad core err", 32'(r_err), 1);
    chk("R5 bad core no sel", 32'(r_sel), 0);
    @(negedge clk);
    chk("R5 err one cycle", 32'(bus_err), 0);
    for (int k = 0; k < NC; k++) begin
      acc(k + 1, 0, 0, 0, 0, 4'hF);
      chk("R5 write dropped", r_data, expm[k][0]);
    end
    acc(0, 0, 3, 0, 0, 4'hF);
    chk("R5 bad core reads zero", r_data, 0);
  endtask

  task automatic t_miss;
    acc(4, 0, 0, 1, 32'h7777_7777, 4'hF);
    chk("R6 miss no sel", 32'(r_sel), 0);
    chk("R6 miss no err", 32'(r_err), 0);
    acc(7, 0, 1, 0, 0, 4'hF);
    chk("R6 miss reads zero", r_data, 0);
    chk("R6 miss no err read", 32'(r_err), 0);
    for (int k = 0; k < NC; k++) begin
      acc(k + 1, 0, 0, 0, 0, 4'hF);
      chk("R6 write dropped", r_data, expm[k][0]);
    end
  endtask

  task automatic t_irq;
    for (int p = 0; p < (1 << NC); p++) begin
      @(negedge clk);
      tmr_irq = NC'(p);
      #1;
      chk("R8 irq follow", 32'(irq_out), 32'(p));
    end
    tmr_irq = '0;
  endtask

  initial begin
    for (int k = 0; k < NC; k++)
      for (int w = 0; w < 8; w++) expm[k][w] = seed(k, w);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_fixed();
    t_latency();
    t_partial();
    t_badcore();
    t_miss();
    t_irq();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule